// File: doc/BRIEF.md
# Up-Counting PWM Timer with Split Interrupt Lines

This block is a free-running timer for generating a single pulse-width modulated output. A 16-bit counter counts from zero up to a programmable period value and then returns to zero. A second compare value, the duty value, pulls the output low partway through each period. When the counter lands on the period value, the output is driven high again.

Three events can raise interrupts: the period match, the duty match and the counter wrap. The period match has a request line of its own. The processor clears that request with a one-clock acknowledge pulse, so no register read is needed. The duty match and the wrap share a second line. Software services that line by reading a vector register. The vector names the most urgent pending source, and the read clears only that one flag.

Software drives the block through a simple register port with a combinational read path. The count mode is either stop or up.

Top module: `upPwmTimer`

## Requirements
- R1: The register map is: 0 control, 1 count (read only), 2 period, 3 duty, 4 period control, 5 duty control, 6 vector. In up mode the count read at address 1 advances by one each clock from 0 to the period value and then returns to 0, so one period lasts period+1 clocks.
- R2: The period flag (bit 1 at address 4) is set on the clock where the counter becomes equal to the period value. The wrap flag (bit 4 at address 0) is set one clock later, when the counter returns to 0. Writing 1 to either flag bit clears that flag.
- R3: There are three interrupt enables: bit 0 at address 4 (period), bit 0 at address 5 (duty) and bit 3 at address 0 (wrap). Each enable only lets its own flag reach a request line. A flag whose enable is off raises nothing and does not show in the vector.
- R4: `irqPeriod` is high exactly when the period flag and its enable are both set. A read of the vector register leaves it unchanged.
- R5: A one-clock pulse on `irqPeriodAck` clears the period flag without any register read. If a new period match occurs in the same clock, the flag stays set.
- R6: The vector register at address 6 returns one of three values:
  - 2 when the duty flag (bit 1 at address 5) is set and enabled;
  - otherwise 10 when the wrap flag is set and enabled;
  - otherwise 0.

  `irqShared` is high exactly when the vector is non-zero.
- R7: A read of the vector register clears only the flag that it reported. Any other pending flag stays set, and `irqShared` stays high while one remains.
- R8: The PWM output uses reset/set behaviour:
  - It is high while the count is the period value or below the duty value, and low otherwise, so it is high for duty+1 clocks of each period.
  - The duty match clears the output and the period match sets it, each taking effect one clock after the match.
- R9: Writes to the period and duty registers take effect on the next clock. If the duty value is equal to or greater than the period value, the output stays high for the whole period, because a set wins over a clear.
- R10: Control bits [1:0] select the mode: 01 is up, and any other value is stop. In stop mode the counter holds and no flag is set.
- R11: Writing 1 to control bit 2 resets the counter to 0 on the next clock. That bit is not stored and reads back as 0.
- R12: After reset the count, the period value, the duty value, every flag, every enable, the PWM output, both request lines and the vector all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdEn | input | 1 | Read strobe; a read at the vector address clears the reported flag |
| regRdData | output | 16 | Combinational read data |
| irqPeriodAck | input | 1 | Acknowledge for the period interrupt; clears the period flag |
| pwmOut | output | 1 | PWM output pin |
| irqPeriod | output | 1 | Dedicated period-match interrupt request |
| irqShared | output | 1 | Shared duty/wrap interrupt request |

## Verification
The bench builds the block with the default 16-bit counter. It programs small periods at run time (1, 4, 5, 6, 9, 50), so many wraps occur in a few hundred clocks. Periods of 1 and duty values of 0, equal to the period and above the period bring the clamp and tie cases of the output within reach. A period of 50 leaves a quiet window in which stop mode, acknowledge and vector reads can be sequenced with no new match interfering.

// File: rtl/upPwmTimerPkg.sv
package upPwmTimerPkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_COUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] REG_PERIOD  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_DUTY    = 3'd3;
  localparam logic [ADDR_W-1:0] REG_PERCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_DUTYCTL = 3'd5;
  localparam logic [ADDR_W-1:0] REG_VECTOR  = 3'd6;

  localparam logic [1:0] MODE_UP = 2'b01;

  localparam logic [3:0] VEC_NONE = 4'd0;
  localparam logic [3:0] VEC_DUTY = 4'd2;
  localparam logic [3:0] VEC_WRAP = 4'd10;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic clr;
    logic periodWr;
    logic dutyWr;
  } ctrlStrb_t;

  // events from datapath to control
  typedef struct packed {
    logic periodMatch;
    logic dutyMatch;
    logic wrapEvt;
  } tmrEvt_t;

endpackage

// File: rtl/upPwmDatapath.sv
module upPwmDatapath
  import upPwmTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output tmrEvt_t          evt,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] dutyVal,
  output logic             pwmOut
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntNext;
  logic             atTop;

  assign atTop = (cntVal >= periodVal);

  always_comb begin
    if (strb.clr)      cntNext = '0;
    else if (strb.run) cntNext = atTop ? '0 : cntVal + ONE;
    else               cntNext = cntVal;
  end

  always_comb begin
    evt.periodMatch = strb.run && !strb.clr && (cntNext == periodVal);
    evt.dutyMatch   = strb.run && !strb.clr && (cntNext == dutyVal);
    evt.wrapEvt     = strb.run && !strb.clr && atTop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal    <= '0;
      periodVal <= '0;
      dutyVal   <= '0;
      pwmOut    <= 1'b0;
    end else begin
      cntVal <= cntNext;
      if (strb.periodWr) periodVal <= wrData;
      if (strb.dutyWr)   dutyVal   <= wrData;
      // set wins over clear on a tie
      if (evt.periodMatch)    pwmOut <= 1'b1;
      else if (evt.dutyMatch) pwmOut <= 1'b0;
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clr && !strb.periodWr && (cntVal < periodVal))
      |=> (cntVal == $past(cntVal) + ONE));

  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clr) |=> $stable(cntVal));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cntVal == '0));

  assert_pwm_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    evt.periodMatch |=> pwmOut);

  assert_pwm_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evt.dutyMatch && !evt.periodMatch) |=> !pwmOut);

endmodule

// File: rtl/upPwmControl.sv
module upPwmControl
  import upPwmTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [4:0]        wrBits,
  input  logic              irqAck,
  input  tmrEvt_t           evt,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  periodVal,
  input  logic [CNT_W-1:0]  dutyVal,
  output ctrlStrb_t         strb,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqPeriod,
  output logic              irqShared
);

  logic [1:0] mode;
  logic       periodIe, dutyIe, wrapIe;
  logic       periodFlag, dutyFlag, wrapFlag;
  logic [3:0] vector;
  logic       wrCtrl, wrPerCtl, wrDutyCtl, vecRead;

  assign wrCtrl    = regWrEn && (regAddr == REG_CTRL);
  assign wrPerCtl  = regWrEn && (regAddr == REG_PERCTL);
  assign wrDutyCtl = regWrEn && (regAddr == REG_DUTYCTL);
  assign vecRead   = regRdEn && (regAddr == REG_VECTOR);

  always_comb begin
    strb.run      = (mode == MODE_UP);
    strb.clr      = wrCtrl && wrBits[2];
    strb.periodWr = regWrEn && (regAddr == REG_PERIOD);
    strb.dutyWr   = regWrEn && (regAddr == REG_DUTY);
  end

  // duty channel outranks the wrap on the shared line
  always_comb begin
    if (dutyFlag && dutyIe)      vector = VEC_DUTY;
    else if (wrapFlag && wrapIe) vector = VEC_WRAP;
    else                         vector = VEC_NONE;
  end

  assign irqPeriod = periodFlag && periodIe;
  assign irqShared = (vector != VEC_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= 2'b00;
      periodIe   <= 1'b0;
      dutyIe     <= 1'b0;
      wrapIe     <= 1'b0;
      periodFlag <= 1'b0;
      dutyFlag   <= 1'b0;
      wrapFlag   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        mode   <= wrBits[1:0];
        wrapIe <= wrBits[3];
      end
      if (wrPerCtl)  periodIe <= wrBits[0];
      if (wrDutyCtl) dutyIe   <= wrBits[0];

      // clears first, a coincident event then wins
      if (wrPerCtl && wrBits[1]) periodFlag <= 1'b0;
      if (irqAck)                periodFlag <= 1'b0;
      if (evt.periodMatch)       periodFlag <= 1'b1;

      if (wrDutyCtl && wrBits[1])          dutyFlag <= 1'b0;
      if (vecRead && vector == VEC_DUTY)   dutyFlag <= 1'b0;
      if (evt.dutyMatch)                   dutyFlag <= 1'b1;

      if (wrCtrl && wrBits[4])             wrapFlag <= 1'b0;
      if (vecRead && vector == VEC_WRAP)   wrapFlag <= 1'b0;
      if (evt.wrapEvt)                     wrapFlag <= 1'b1;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_CTRL:    rdData = CNT_W'({wrapFlag, wrapIe, 1'b0, mode});
      REG_COUNT:   rdData = cntVal;
      REG_PERIOD:  rdData = periodVal;
      REG_DUTY:    rdData = dutyVal;
      REG_PERCTL:  rdData = CNT_W'({periodFlag, periodIe});
      REG_DUTYCTL: rdData = CNT_W'({dutyFlag, dutyIe});
      REG_VECTOR:  rdData = CNT_W'(vector);
      default:     rdData = '0;
    endcase
  end

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !evt.periodMatch) |=> !periodFlag);

  assert_match_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    evt.periodMatch |=> periodFlag);

  assert_wrap_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrapEvt |=> wrapFlag);

  assert_vec_clears_duty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecRead && vector == VEC_DUTY && !evt.dutyMatch) |=> !dutyFlag);

  assert_vec_keeps_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecRead && vector == VEC_DUTY && wrapFlag) |=> wrapFlag);

  assert_period_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vecRead && irqPeriod && !irqAck && !wrPerCtl) |=> irqPeriod);

  assert_shared_line_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqShared |-> ((dutyFlag && dutyIe) || (wrapFlag && wrapIe)));

  assert_stop_no_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !periodFlag) |=> !periodFlag);

endmodule

// File: rtl/upPwmTimer.sv
module upPwmTimer
  import upPwmTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  input  logic             regRdEn,
  output logic [CNT_W-1:0] regRdData,
  input  logic             irqPeriodAck,
  output logic             pwmOut,
  output logic             irqPeriod,
  output logic             irqShared
);

  ctrlStrb_t        strb;
  tmrEvt_t          evt;
  logic [CNT_W-1:0] cntVal, periodVal, dutyVal;

  upPwmControl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .wrBits   (regWrData[4:0]),
    .irqAck   (irqPeriodAck),
    .evt      (evt),
    .cntVal   (cntVal),
    .periodVal(periodVal),
    .dutyVal  (dutyVal),
    .strb     (strb),
    .rdData   (regRdData),
    .irqPeriod(irqPeriod),
    .irqShared(irqShared)
  );

  upPwmDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .evt      (evt),
    .cntVal   (cntVal),
    .periodVal(periodVal),
    .dutyVal  (dutyVal),
    .pwmOut   (pwmOut)
  );

endmodule

// File: tb/upPwmTimer_bench.sv
`timescale 1ns/100ps
module upPwmTimer_bench;

  localparam int W = 16;
  localparam int NV = 6;
  // table: period, duty, expected high clocks per period (R8, R9)
  localparam int TP[NV] = '{9, 9, 9, 9, 4, 1};
  localparam int TD[NV] = '{3, 0, 9, 15, 2, 0};
  localparam int TH[NV] = '{4, 1, 10, 10, 3, 1};

  logic clk = 0, rstN = 0;
  logic [2:0] regAddr = 0;
  logic regWrEn = 0, regRdEn = 0, irqPeriodAck = 0;
  logic [W-1:0] regWrData = 0;
  logic [W-1:0] regRdData;
  logic pwmOut, irqPeriod, irqShared;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  upPwmTimer #(.CNT_W(W)) u_upPwmTimer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .irqPeriodAck(irqPeriodAck), .pwmOut(pwmOut), .irqPeriod(irqPeriod),
    .irqShared(irqShared));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input int d);
    @(negedge clk);
    regAddr = a; regWrData = W'(d); regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  // read without side effect inside the low phase
  task automatic peek(input logic [2:0] a, output int d);
    regAddr = a; #0.2;
    d = int'(regRdData);
  endtask

  // read with read strobe (vector read clears a flag)
  task automatic rdReg(input logic [2:0] a, output int d);
    @(negedge clk);
    regAddr = a; regRdEn = 1; #0.2;
    d = int'(regRdData);
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, c, hi, prev;
    waitClk(3);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    peek(3'd1, v); check("R12 count", v, 0);
    peek(3'd6, v); check("R12 vector", v, 0);
    peek(3'd4, v); check("R12 perctl", v, 0);
    check("R12 pwm", pwmOut, 0);
    check("R12 irqs", {irqPeriod, irqShared}, 0);

    // R8/R9 table walk
    for (int i = 0; i < NV; i++) begin
      wrReg(3'd0, 32'h4);
      wrReg(3'd2, TP[i]);
      wrReg(3'd3, TD[i]);
      wrReg(3'd0, 32'h5);
      waitClk(2 * (TP[i] + 1) + 2);
      hi = 0;
      for (int k = 0; k <= TP[i]; k++) begin
        if (pwmOut) hi++;
        @(negedge clk);
      end
      check($sformatf("R8/R9 vec%0d high clocks", i), hi, TH[i]);
    end

    // R1 count sequence, period 5
    wrReg(3'd0, 32'h4);
    wrReg(3'd2, 5);
    wrReg(3'd0, 32'h5);
    waitClk(1);
    peek(3'd1, prev);
    c = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      peek(3'd1, v);
      if (v != ((prev == 5) ? 0 : prev + 1) || v > 5) c++;
      prev = v;
    end
    check("R1 count steps 0..5", c, 0);

    // R2 flag timing, period 4
    wrReg(3'd0, 32'h14);
    wrReg(3'd4, 32'h2);
    wrReg(3'd2, 4);
    wrReg(3'd3, 7);
    wrReg(3'd0, 32'h5);
    c = 0;
    for (int k = 0; k < 20; k++) begin
      peek(3'd4, v);
      if (v[1]) break;
      @(negedge clk);
      c++;
    end
    peek(3'd1, v); check("R2 count at period flag", v, 4);
    peek(3'd0, v); check("R2 wrap not yet", v[4], 0);
    @(negedge clk);
    peek(3'd0, v); check("R2 wrap one clock later", v[4], 1);
    peek(3'd1, v); check("R2 count at wrap", v, 0);

    // R11 clear bit
    wrReg(3'd2, 50);
    waitClk(20);
    wrReg(3'd0, 32'h5);
    peek(3'd1, v); check("R11 count cleared", v, 0);
    peek(3'd0, v); check("R11 clear bit reads 0", v[2], 0);
    @(negedge clk);
    peek(3'd1, v); check("R11 count resumes", v, 1);

    // R10 stop mode: hold, no flags
    wrReg(3'd0, 32'h10);
    wrReg(3'd4, 32'h2);
    wrReg(3'd5, 32'h2);
    peek(3'd1, prev);
    waitClk(30);
    peek(3'd1, v); check("R10 count held", v, prev);
    peek(3'd4, v); check("R10 no period flag", v[1], 0);
    peek(3'd5, v); check("R10 no duty flag", v[1], 0);
    peek(3'd0, v); check("R10 no wrap flag", v[4], 0);

    // R3 independent enables: only wrap enabled
    wrReg(3'd2, 6);
    wrReg(3'd3, 2);
    wrReg(3'd4, 32'h0);
    wrReg(3'd5, 32'h0);
    wrReg(3'd0, 32'h0D);
    waitClk(20);
    wrReg(3'd0, 32'h08);
    peek(3'd4, v); check("R3 period flag pending", v[1], 1);
    check("R3 irqPeriod gated", irqPeriod, 0);
    check("R3 irqShared from wrap", irqShared, 1);
    peek(3'd6, v); check("R3 disabled duty not in vector", v, 10);
    wrReg(3'd4, 32'h1);
    check("R3 irqPeriod once enabled", irqPeriod, 1);

    // R6/R7/R4 vector priority and selective clear
    wrReg(3'd5, 32'h1);
    peek(3'd6, v); check("R6 duty outranks wrap", v, 2);
    rdReg(3'd6, v); check("R6 vector read value", v, 2);
    peek(3'd6, v); check("R7 wrap still reported", v, 10);
    check("R7 irqShared stays", irqShared, 1);
    check("R4 irqPeriod unaffected by read", irqPeriod, 1);
    rdReg(3'd6, v); check("R7 second read value", v, 10);
    peek(3'd6, v); check("R7 vector now empty", v, 0);
    check("R6 irqShared low when vector 0", irqShared, 0);

    // R5 acknowledge
    @(negedge clk);
    irqPeriodAck = 1;
    @(negedge clk);
    irqPeriodAck = 0;
    peek(3'd4, v); check("R5 ack clears period flag", v[1], 0);
    check("R5 irqPeriod drops", irqPeriod, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule